// File: doc/BRIEF.md
# FSK Burst Cell Synchronizer and Deserializer

This block sits behind an external phase-locked FSK demodulator. That demodulator supplies two digital lines: a data line that carries the inverse of the demodulated bit, and an active-low lock line that is low while a burst is present. The block brings both lines into the system clock domain and filters the lock line. It treats a qualified falling edge of lock as the start of the first cell of a burst.

From that point it times each cell against a fixed period in clock cycles, with no clock recovery from data edges. It samples the data line once per cell at a fixed offset, which defaults to the middle of the cell. It inverts each sample and shifts it into a word. When the burst has been collected, the block presents the word together with a one-cycle valid pulse.

If lock goes away before all cells have been sampled, the partial word is thrown away and a one-cycle abort pulse is raised. After a good burst, the block ignores the lines until lock has been released. Only then does it look for the next burst.

Top module: `fsk_burst_deser`

## Requirements
- R1: While reset is asserted and on the first cycle after it, word_o is all zeros and word_valid_o and abort_o are low.
- R2: A burst starts when lock_n_i has been seen low for DEBOUNCE consecutive clocks after the two-stage synchronizer. A low pulse that is shorter than DEBOUNCE clocks starts nothing and produces neither a valid nor an abort pulse.
- R3: Each stored bit is the logical NOT of data_n_i at its sample point. data_n_i = 0 stores a 1.
- R4: The bit of the first cell lands in bit NUM_CELLS-1 (the MSB) of word_o, and the bit of the last cell lands in bit 0.
- R5: Cell k (counting from 0) is sampled SAMPLE_AT clocks into the cell, where cell k starts k*CELL_CYCLES clocks after burst start. Data outside a window around that point has no effect on the word. Defaults: CELL_CYCLES = 26040 and SAMPLE_AT = 13020.
- R6: After NUM_CELLS = 32 samples, word_o takes the assembled word and word_valid_o is high for exactly one clock. word_o holds its value until the next complete burst.
- R7: If lock is released (debounced high) before the last sample, abort_o is high for exactly one clock, no valid pulse is issued, and word_o keeps its previous value.
- R8: After a complete burst, holding lock_n_i low for any further time produces no second valid pulse. A new burst is accepted only after lock has been released.
- R9: A high pulse on lock_n_i shorter than DEBOUNCE clocks during a burst neither aborts it nor disturbs its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_n_i | input | 1 | Inverted demodulated bit from the demodulator |
| lock_n_i | input | 1 | Lock indicator, low while a burst is present |
| word_o | output | NUM_CELLS | Last complete burst, first cell in the MSB |
| word_valid_o | output | 1 | One-clock pulse when word_o is updated |
| abort_o | output | 1 | One-clock pulse when a burst is cut short |

## Verification
The assertions assume that the demodulator holds lock low for a whole burst, apart from glitches, and that the data line is settled near each sample point. They also assume that lock is not released and re-acquired faster than the debounce filter can follow. The stimulus uses shortened cell timing. It changes data only at cell boundaries, and drives deliberately wrong values only far from the sampling offset, so that any dependence on off-centre data shows up in the word. Lock glitches are kept at two clocks, below the three-sample filter, while real releases last many cells.

// File: rtl/fsk_sync_pkg.sv
package fsk_sync_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } deser_state_e;

  // width of a counter that must hold values 0 .. n-1
  function automatic int ctr_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // default sampling offset: the middle of a cell
  function automatic int mid_cell(input int cell_cycles);
    return cell_cycles / 2;
  endfunction

endpackage

// File: rtl/fsk_in_sync.sv
module fsk_in_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  input  logic [WIDTH-1:0] reset_val_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= reset_val_i;
      else if (s == 0) stg[s] <= async_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/fsk_lock_filter.sv
module fsk_lock_filter #(
  parameter int DEBOUNCE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_n_s_i,
  output logic present_o,
  output logic acquire_o,
  output logic release_o
);
  logic [DEBOUNCE-1:0] hist;
  logic                level_n;

  // a flip needs DEBOUNCE stored samples all opposite to the held level
  assign acquire_o = level_n  && (hist == '0);
  assign release_o = !level_n && (&hist);
  assign present_o = !level_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '1;
      level_n <= 1'b1;
    end else begin
      hist <= {hist[(DEBOUNCE > 1 ? DEBOUNCE-2 : 0):0], lock_n_s_i};
      if (acquire_o)      level_n <= 1'b0;
      else if (release_o) level_n <= 1'b1;
    end
  end
endmodule

// File: rtl/fsk_cell_timer.sv
module fsk_cell_timer #(
  parameter int CELL_CYCLES = 26040,
  parameter int SAMPLE_AT   = 13020
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic sample_o
);
  import fsk_sync_pkg::*;
  localparam int CW = ctr_width(CELL_CYCLES);
  localparam logic [CW-1:0] LAST_CNT = CW'(CELL_CYCLES - 1);
  localparam logic [CW-1:0] SAMP_CNT = CW'(SAMPLE_AT);

  logic [CW-1:0] cnt;

  assign sample_o = run_i && (cnt == SAMP_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (clear_i)                 cnt <= '0;
    else if (run_i && cnt == LAST_CNT) cnt <= '0;
    else if (run_i)                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fsk_shift_word.sv
module fsk_shift_word #(
  parameter int NUM_CELLS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [NUM_CELLS-1:0] next_word_o,
  output logic                 last_o
);
  import fsk_sync_pkg::*;
  localparam int BW = ctr_width(NUM_CELLS);
  localparam logic [BW-1:0] LAST_BIT = BW'(NUM_CELLS - 1);

  logic [NUM_CELLS-1:0] acc;
  logic [BW-1:0]        taken;

  // earliest cell ends up in the MSB after NUM_CELLS shifts
  assign next_word_o = {acc[NUM_CELLS-2:0], bit_i};
  assign last_o      = shift_i && (taken == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      taken <= '0;
    end else if (clear_i) begin
      acc   <= '0;
      taken <= '0;
    end else if (shift_i) begin
      acc   <= next_word_o;
      taken <= taken + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_burst_deser.sv
module fsk_burst_deser #(
  parameter int NUM_CELLS   = 32,
  parameter int CELL_CYCLES = 26040,
  parameter int SAMPLE_AT   = fsk_sync_pkg::mid_cell(CELL_CYCLES),
  parameter int DEBOUNCE    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 data_n_i,
  input  logic                 lock_n_i,
  output logic [NUM_CELLS-1:0] word_o,
  output logic                 word_valid_o,
  output logic                 abort_o
);
  import fsk_sync_pkg::*;

  deser_state_e state;
  logic [1:0] synced;
  logic data_n_s, lock_n_s;
  logic lock_present, lock_acquire, lock_release;
  logic in_run, burst_start, lock_lost, sample_tick, last_bit;
  logic [NUM_CELLS-1:0] next_word;

  fsk_in_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({data_n_i, lock_n_i}),
    .reset_val_i(2'b11),
    .sync_o(synced)
  );
  assign data_n_s = synced[1];
  assign lock_n_s = synced[0];

  fsk_lock_filter #(.DEBOUNCE(DEBOUNCE)) u_filt (
    .clk(clk), .rst_n(rst_n), .lock_n_s_i(lock_n_s),
    .present_o(lock_present), .acquire_o(lock_acquire), .release_o(lock_release)
  );

  assign in_run      = (state == ST_RUN);
  assign burst_start = (state == ST_IDLE) && lock_acquire;
  assign lock_lost   = in_run && lock_release;

  fsk_cell_timer #(.CELL_CYCLES(CELL_CYCLES), .SAMPLE_AT(SAMPLE_AT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(burst_start),
    .run_i(in_run && !lock_lost), .sample_o(sample_tick)
  );

  fsk_shift_word #(.NUM_CELLS(NUM_CELLS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear_i(burst_start),
    .shift_i(sample_tick), .bit_i(!data_n_s),
    .next_word_o(next_word), .last_o(last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      abort_o      <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      abort_o      <= 1'b0;
      unique case (state)
        ST_IDLE: if (burst_start) state <= ST_RUN;
        ST_RUN: begin
          if (lock_lost) begin
            abort_o <= 1'b1;
            state   <= ST_IDLE;
          end else if (last_bit) begin
            word_o       <= next_word;
            word_valid_o <= 1'b1;
            state        <= ST_HOLD;
          end
        end
        ST_HOLD: if (!lock_present) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsk_burst_deser_chk.sv
module fsk_burst_deser_chk #(
  parameter int NUM_CELLS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CELLS-1:0] word_o,
  input logic                 word_valid_o,
  input logic                 abort_o,
  input logic                 sample_tick,
  input logic                 in_run
);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  p_abort_or_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && word_valid_o));

  p_abort_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(in_run));

  p_sample_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> in_run);

  p_valid_after_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(sample_tick));
endmodule

bind fsk_burst_deser fsk_burst_deser_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_o(word_o), .word_valid_o(word_valid_o),
  .abort_o(abort_o), .sample_tick(sample_tick), .in_run(in_run)
);

// File: tb/fsk_burst_deser_test.sv
`timescale 1ns/1ps
module fsk_burst_deser_test;
  localparam int N    = 32;
  localparam int CELL = 40;
  localparam int WLO  = 14;   // correct data window within a cell
  localparam int WHI  = 34;
  localparam int NV   = 5;
  localparam logic [N-1:0] VECS [NV] = '{32'hA5C3_0F96, 32'h0000_0001,
                                         32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000};

  logic clk = 0, rst_n = 0, data_n = 1, lock_n = 1;
  logic [N-1:0] word;
  logic valid, abort_p;
  int total = 0, bad = 0;
  int vcnt = 0, acnt = 0, dbl = 0;
  logic [N-1:0] vword = '0;
  logic pv = 0, pa = 0;

  always #2.5 clk = ~clk;

  fsk_burst_deser #(.NUM_CELLS(N), .CELL_CYCLES(CELL), .DEBOUNCE(3)) uut (
    .clk(clk), .rst_n(rst_n), .data_n_i(data_n), .lock_n_i(lock_n),
    .word_o(word), .word_valid_o(valid), .abort_o(abort_p)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin vcnt++; vword = word; end
      if (abort_p) acnt++;
      if ((valid && pv) || (abort_p && pa)) dbl++;
      pv = valid; pa = abort_p;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one burst: stop_cell < N releases lock early, glitch_cell gets a 2-clock high on lock
  task automatic burst(input logic [N-1:0] w, input int stop_cell, input int glitch_cell, input int hold);
    for (int k = 0; k < stop_cell; k++) begin
      for (int c = 0; c < CELL; c++) begin
        lock_n = (k == glitch_cell && c >= 2 && c < 4);
        data_n = (c >= WLO && c <= WHI) ? ~w[N-1-k] : w[N-1-k];
        @(negedge clk);
      end
    end
    lock_n = 0;
    repeat (hold) @(negedge clk);
    lock_n = 1; data_n = 1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0, a0;
    logic [N-1:0] w0;
    repeat (3) @(negedge clk);
    chk(word == '0 && !valid && !abort_p, "R1 in reset", word, '0);
    rst_n = 1;
    @(negedge clk);
    chk(word == '0 && !valid && !abort_p, "R1 after reset", word, '0);

    // vector table: stimulus word, expected word identical (R3 inversion, R4 MSB first, R5 mid-cell)
    for (int i = 0; i < NV; i++) begin
      v0 = vcnt;
      burst(VECS[i], N, -1, 10);
      chk(vcnt == v0 + 1, "R6 one valid per burst", N'(vcnt - v0), N'(1));
      chk(vword == VECS[i], "R3 R4 R5 word", vword, VECS[i]);
      chk(word == VECS[i], "R6 word held", word, VECS[i]);
    end

    // R7 early release
    w0 = word; v0 = vcnt; a0 = acnt;
    burst(32'h1234_5678, 10, -1, 0);
    chk(acnt == a0 + 1, "R7 abort pulse", N'(acnt - a0), N'(1));
    chk(vcnt == v0, "R7 no valid", N'(vcnt - v0), N'(0));
    chk(word == w0, "R7 word kept", word, w0);

    // R2 short low glitch on lock starts nothing
    v0 = vcnt; a0 = acnt;
    lock_n = 0; repeat (2) @(negedge clk); lock_n = 1;
    repeat (CELL * 3) @(negedge clk);
    chk(acnt == a0 && vcnt == v0, "R2 glitch ignored", N'(acnt - a0 + vcnt - v0), N'(0));

    // R9 short high glitch mid-burst
    v0 = vcnt; a0 = acnt;
    burst(32'hC0DE_5A17, N, 5, 10);
    chk(acnt == a0, "R9 no abort", N'(acnt - a0), N'(0));
    chk(vword == 32'hC0DE_5A17 && vcnt == v0 + 1, "R9 word", vword, 32'hC0DE_5A17);

    // R8 long hold after burst, then re-arm
    v0 = vcnt;
    burst(32'h0F0F_F0F0, N, -1, CELL * 5);
    chk(vcnt == v0 + 1, "R8 single valid during hold", N'(vcnt - v0), N'(1));
    burst(32'h7E81_3CC3, N, -1, 10);
    chk(vword == 32'h7E81_3CC3 && vcnt == v0 + 2, "R8 re-arm", vword, 32'h7E81_3CC3);

    chk(dbl == 0, "R6 R7 pulse width", N'(dbl), N'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule